// File: doc/BRIEF.md
# Tapped-Delay Event Timestamp Encoder

This block converts a single asynchronous event into a timestamp. A free-running counter in the system clock domain supplies the coarse time in whole clock cycles. A row of tap flip-flops, all sampling the same event signal at staggered delays, supplies the fine time. The physical delay chain lives outside this block, so the sampled tap vector arrives on an input port.

The event is passed through a two-stage synchronizer. An edge-select input chooses whether a rising or a falling transition counts as the event. When the chosen edge is detected, the block latches the counter value and the tap vector together. One cycle later it presents the coarse count, the index of the highest set tap and the combined time in picoseconds, with a single-cycle valid strobe.

The clock period and the per-tap delay are parameters given in picoseconds. The combined time output is sized so that the largest coarse count plus the largest fine index cannot overflow it.

Top module: `tdc_stamp`

## Requirements
- R1: The coarse counter clears on reset and then advances by one on every clock edge, wrapping modulo 2^CNT_W. A capture records the counter value held just before the increment in the capture cycle, including when that value is 2^CNT_W-1.
- R2: `evt_in` passes through two synchronizer flops before edge detection. With `edge_sel`=1 only a 0-to-1 transition is an event; with `edge_sel`=0 only a 1-to-0 transition is an event. A transition of the other polarity produces no valid strobe.
- R3: `stamp_valid` rises after the fourth rising clock edge that follows a qualifying change of `evt_in`. `stamp_coarse` then equals (N+2) mod 2^CNT_W, where N is the number of clock edges after reset release that preceded the change. The tap vector is sampled on the third of those edges.
- R4: `stamp_fine` is the index of the highest `taps` bit that is 1, with bit i standing for tap i. An all-zero vector gives 0, and an all-ones vector gives NUM_TAPS-1.
- R5: `stamp_time` equals `stamp_coarse`*CLK_PS + `stamp_fine`*TAP_PS, computed without overflow for every coarse and fine value.
- R6: `stamp_valid` is high for exactly one cycle per event. Between events, the stamp outputs keep their last values.
- R7: A synchronous `rst` clears the counter, the captured values, all stamp outputs and `stamp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_sel | input | 1 | 1 = rising edge is the event, 0 = falling edge is the event |
| evt_in | input | 1 | Asynchronous event signal |
| taps | input | NUM_TAPS | Sampled delay-chain taps, bit i = tap i |
| stamp_valid | output | 1 | One-cycle strobe for a new stamp |
| stamp_coarse | output | CNT_W | Captured clock-cycle count |
| stamp_fine | output | $clog2(NUM_TAPS) | Index of the highest set tap |
| stamp_time | output | TIME_W | Combined time in picoseconds |

## Verification
The assertions assume that `edge_sel` changes only while the synchronized event level is steady. They also assume that `taps` is stable around the sampling edge. The bench changes `evt_in`, `taps` and `edge_sel` only on falling clock edges. It switches edge polarity only while the event line has been idle for several cycles, and it holds `taps` from the event until the stamp has been checked. Events are spaced nine cycles apart, so each one is captured and issued before the next arrives.

// File: rtl/tdc_stamp.sv
module tdc_stamp #(
  parameter int NUM_TAPS = 16,
  parameter int CNT_W    = 16,
  parameter int CLK_PS   = 8000,
  parameter int TAP_PS   = 50,
  localparam int IDX_W   = $clog2(NUM_TAPS),
  localparam longint MAX_T = ((longint'(1) << CNT_W) - 1) * CLK_PS + longint'(NUM_TAPS - 1) * TAP_PS,
  localparam int TIME_W  = $clog2(MAX_T + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                edge_sel,
  input  logic                evt_in,
  input  logic [NUM_TAPS-1:0] taps,
  output logic                stamp_valid,
  output logic [CNT_W-1:0]    stamp_coarse,
  output logic [IDX_W-1:0]    stamp_fine,
  output logic [TIME_W-1:0]   stamp_time
);

  logic [CNT_W-1:0]    cnt;
  logic [2:0]          sync_q;
  logic                pending;
  logic [CNT_W-1:0]    cap_cnt;
  logic [NUM_TAPS-1:0] cap_taps;
  logic [IDX_W-1:0]    hi_idx;
  logic                edge_hit;

  assign edge_hit = edge_sel ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (cap_taps[i]) hi_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      sync_q       <= '0;
      pending      <= 1'b0;
      cap_cnt      <= '0;
      cap_taps     <= '0;
      stamp_valid  <= 1'b0;
      stamp_coarse <= '0;
      stamp_fine   <= '0;
      stamp_time   <= '0;
    end else begin
      cnt         <= cnt + 1'b1;
      sync_q      <= {sync_q[1:0], evt_in};
      stamp_valid <= 1'b0;
      if (pending) begin
        pending      <= 1'b0;
        stamp_valid  <= 1'b1;
        stamp_coarse <= cap_cnt;
        stamp_fine   <= hi_idx;
        stamp_time   <= TIME_W'(cap_cnt) * TIME_W'(CLK_PS) + TIME_W'(hi_idx) * TIME_W'(TAP_PS);
      end else if (edge_hit) begin
        pending  <= 1'b1;
        cap_cnt  <= cnt;
        cap_taps <= taps;
      end
    end
  end

endmodule

// File: rtl/tdc_stamp_chk.sv
module tdc_stamp_chk #(
  parameter int NUM_TAPS = 16,
  parameter int CNT_W    = 16,
  parameter int CLK_PS   = 8000,
  parameter int TAP_PS   = 50,
  parameter int IDX_W    = 4,
  parameter int TIME_W   = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic              pending,
  input logic              stamp_valid,
  input logic [CNT_W-1:0]  stamp_coarse,
  input logic [IDX_W-1:0]  stamp_fine,
  input logic [TIME_W-1:0] stamp_time
);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == $past(cnt) + 1'b1);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stamp_valid |=> !stamp_valid);

  // R3
  capture_before_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stamp_valid) |-> $past(pending));

  // R5
  time_sum_chk: assert property (@(posedge clk) disable iff (rst)
    stamp_valid |-> stamp_time == TIME_W'(stamp_coarse) * TIME_W'(CLK_PS) + TIME_W'(stamp_fine) * TIME_W'(TAP_PS));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stamp_valid && !$past(rst) |-> $stable(stamp_time) && $stable(stamp_coarse));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !stamp_valid && cnt == '0 && stamp_time == '0);

endmodule

bind tdc_stamp tdc_stamp_chk #(
  .NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W), .CLK_PS(CLK_PS), .TAP_PS(TAP_PS),
  .IDX_W(IDX_W), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .pending(pending),
  .stamp_valid(stamp_valid), .stamp_coarse(stamp_coarse),
  .stamp_fine(stamp_fine), .stamp_time(stamp_time)
);

// File: tb/tdc_stamp_bench.sv
module tdc_stamp_bench;
  localparam int NT = 8;
  localparam int CW = 6;
  localparam int CP = 8000;
  localparam int TP = 125;
  localparam int IW = $clog2(NT);
  localparam longint MT = ((longint'(1) << CW) - 1) * CP + longint'(NT - 1) * TP;
  localparam int TW = $clog2(MT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_sel = 1'b1;
  logic evt_in = 1'b0;
  logic [NT-1:0] taps = '0;
  logic stamp_valid;
  logic [CW-1:0] stamp_coarse;
  logic [IW-1:0] stamp_fine;
  logic [TW-1:0] stamp_time;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tdc_stamp #(.NUM_TAPS(NT), .CNT_W(CW), .CLK_PS(CP), .TAP_PS(TP)) u_tdc_stamp (
    .clk(clk), .rst(rst), .edge_sel(edge_sel), .evt_in(evt_in), .taps(taps),
    .stamp_valid(stamp_valid), .stamp_coarse(stamp_coarse),
    .stamp_fine(stamp_fine), .stamp_time(stamp_time)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int top_bit(logic [NT-1:0] v);
    int r = 0;
    for (int i = 0; i < NT; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    cyc = 0;
    chk("R7 valid", stamp_valid, 0);
    chk("R7 coarse", stamp_coarse, 0);
    chk("R7 fine", stamp_fine, 0);
    chk("R7 time", stamp_time, 0);
  endtask

  // Drive the qualifying change, check the stamp, then drive the opposite change.
  task automatic event_cycle(logic [NT-1:0] pat, logic lvl);
    int c0 = cyc;
    longint ec = (c0 + 2) % (1 << CW);
    int ef = top_bit(pat);
    taps = pat;
    evt_in = lvl;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 early valid", stamp_valid, 0);
    end
    step();
    chk("R3 valid", stamp_valid, 1);
    chk("R1 coarse", stamp_coarse, ec);
    chk("R4 fine", stamp_fine, ef);
    chk("R5 time", stamp_time, ec * CP + longint'(ef) * TP);
    step();
    chk("R6 single", stamp_valid, 0);
    chk("R6 hold", stamp_time, ec * CP + longint'(ef) * TP);
    evt_in = ~lvl;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R2 other edge ignored", stamp_valid, 0);
    end
  endtask

  initial begin
    do_reset();
    step(); step();
    edge_sel = 1'b1;
    for (int p = 0; p < (1 << NT); p++) event_cycle(NT'(p), 1'b1);
    do_reset();
    edge_sel = 1'b0;
    evt_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R2 rising ignored in falling mode", stamp_valid, 0);
    end
    for (int p = 0; p < 70; p++) event_cycle(NT'(p * 37 + 3), 1'b0);
    event_cycle('1, 1'b0);
    event_cycle('0, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule